// File: doc/BRIEF.md
# Word-Serial Radix-2 Montgomery Multiplier

This block computes the Montgomery product Z = X·Y·2^-(n+2) mod M for an odd modulus M of up to n = NWORDS·WORD_W bits. It uses one narrow datapath of WORD_W bits. Operands and the running partial result live in small word-addressed register files, each NWORDS+1 words deep. The extra guard word holds the bits above n that appear when inputs run up to 2M. The outer loop takes one bit of X per pass, n+2 passes in total. The inner loop walks the words from least to most significant, one word per clock. Each step makes two additions, each with its own carry. The first adds the selected multiple of Y. The second adds the multiple of M chosen by the reduce bit. The halving is done across word boundaries while the words are produced.

Software writes X, Y and M word by word through a shared load port and then pulses `start`. After a fixed number of cycles `done` pulses once, and the result words can be read on a combinational read port. The result is not reduced below M. It lies in [0, 2M), so it can feed straight back as an operand of the next product.

The controller has four states. In IDLE it waits for `start`. In WORD it processes one word per cycle. In FOLD it writes the top word together with the leftover carry and advances to the next bit of X. DONE lasts one cycle. The transitions are:
- IDLE→WORD when `start` is seen. This also clears Z, both carries and the counters.
- WORD→WORD while words remain.
- WORD→FOLD after the guard word.
- FOLD→WORD while bits of X remain.
- FOLD→DONE after bit n+1.
- DONE→IDLE unconditionally.

Top module: `mont_mul`

## Requirements
- R1: For odd M < 2^n and X, Y in [0, 2M), the result equals X·Y·2^-(n+2) mod M, or that value plus M.
- R2: The result is always below 2M, so it is valid as an operand of a following product with the same M.
- R3: `done` is high for exactly one cycle. It rises (NWORDS+2)·(n+2)·... more precisely (n+2)·(NWORDS+2) clock edges after the edge that accepts `start`.
- R4: `busy` is high from the edge that accepts `start` until the edge that raises `done`, and it is low while `done` is high. A `start` pulse while busy is ignored.
- R5: Writes on the load port are ignored while `busy` is high.
- R6: After reset, `busy` and `done` are low.
- R7: Z is cleared when `start` is accepted, so the previous result has no effect. With X = 0 the result is exactly 0.
- R8: The load port selects its target with `ld_sel`: 0 = X, 1 = Y, 2 = M. Word address 0 is the least significant word. `rd_data` shows result word `rd_addr`, with word 0 least significant, whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a product (taken in IDLE only) |
| ld_en | input | 1 | Load strobe for one operand word |
| ld_sel | input | 2 | Operand select: 0 X, 1 Y, 2 M |
| ld_addr | input | clog2(NWORDS+1) | Word index of the load |
| ld_data | input | WORD_W | Word value to load |
| rd_addr | input | clog2(NWORDS+1) | Result word index |
| rd_data | output | WORD_W | Result word, valid when not busy |
| busy | output | 1 | Product in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with WORD_W = 4 and NWORDS = 2. That gives an 8-bit modulus, three 4-bit words including the guard word, and ten passes over X. With this size every odd modulus in a wide stride from 3 to 255 can be swept. For each modulus the bench uses the corner operands 0, 1, M−1, M and 2M−1. The four-bit words make carries out of both adders, and a nonzero guard word, occur often. The bench also chains a result back in as an operand. It injects loads and a second `start` in mid-run to confirm that they are ignored.

// File: rtl/mont_pkg.sv
`timescale 1ns/1ps
package mont_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WORD,
        ST_FOLD,
        ST_DONE
    } mm_state_e;

    localparam logic [1:0] SEL_X = 2'd0;
    localparam logic [1:0] SEL_Y = 2'd1;
    localparam logic [1:0] SEL_M = 2'd2;

endpackage

// File: rtl/mm_wordfile.sv
`timescale 1ns/1ps
module mm_wordfile #(
    parameter int W  = 16,
    parameter int N  = 17,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) mem[k] <= '0;
        end else if (clr) begin
            for (int k = 0; k < N; k++) mem[k] <= '0;
        end else if (we && (int'(waddr) < N)) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = (int'(raddr) < N) ? mem[raddr] : '0;

endmodule

// File: rtl/mm_word_pe.sv
`timescale 1ns/1ps
module mm_word_pe #(
    parameter int W = 16
) (
    input  logic         first,
    input  logic         xi,
    input  logic         q_in,
    input  logic         ca_in,
    input  logic         cb_in,
    input  logic [W-1:0] z_in,
    input  logic [W-1:0] y_in,
    input  logic [W-1:0] m_in,
    output logic         q_out,
    output logic         ca_out,
    output logic         cb_out,
    output logic [W-1:0] z_out
);

    logic [W:0] sum_a;
    logic [W:0] sum_b;

    always_comb begin
        sum_a  = {1'b0, z_in} + {{W{1'b0}}, ca_in} + (xi ? {1'b0, y_in} : '0);
        // reduce bit comes from the lowest word only
        q_out  = first ? sum_a[0] : q_in;
        sum_b  = {1'b0, sum_a[W-1:0]} + {{W{1'b0}}, cb_in} + (q_out ? {1'b0, m_in} : '0);
        ca_out = sum_a[W];
        cb_out = sum_b[W];
        z_out  = sum_b[W-1:0];
    end

endmodule

// File: rtl/mont_mul.sv
`timescale 1ns/1ps
module mont_mul
    import mont_pkg::*;
#(
    parameter int  WORD_W = 16,
    parameter int  NWORDS = 16,
    localparam int NW     = NWORDS + 1,
    localparam int AW     = $clog2(NW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ld_en,
    input  logic [1:0]        ld_sel,
    input  logic [AW-1:0]     ld_addr,
    input  logic [WORD_W-1:0] ld_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              busy,
    output logic              done
);

    localparam int NBITS = NWORDS * WORD_W + 2;
    localparam int IW    = $clog2(NBITS + 1);

    mm_state_e state_q, state_d;

    logic [IW-1:0]     bit_q;
    logic [AW-1:0]     word_q;
    logic              ca_q, cb_q, q_q;
    logic [WORD_W-2:0] hold_q;

    logic go, last_word, last_bit, ld_ok;
    logic [AW-1:0]     x_addr, z_raddr, z_waddr;
    logic [WORD_W-1:0] x_word, y_word, m_word, z_word, z_wdata;
    logic              z_we, xi;
    logic              pe_q, pe_ca, pe_cb;
    logic [WORD_W-1:0] pe_z;

    assign go        = start && (state_q == ST_IDLE);
    assign last_word = (word_q == AW'(NW - 1));
    assign last_bit  = (bit_q == IW'(NBITS - 1));
    assign ld_ok     = ld_en && !busy;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        busy    = 1'b0;
        done    = 1'b0;
        z_we    = 1'b0;
        z_waddr = '0;
        z_wdata = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (go) state_d = ST_WORD;
            end
            ST_WORD: begin
                busy = 1'b1;
                if (word_q != '0) begin
                    z_we    = 1'b1;
                    z_waddr = word_q - AW'(1);
                    z_wdata = {pe_z[0], hold_q};
                end
                if (last_word) state_d = ST_FOLD;
            end
            ST_FOLD: begin
                busy    = 1'b1;
                z_we    = 1'b1;
                z_waddr = AW'(NW - 1);
                z_wdata = {ca_q | cb_q, hold_q};
                state_d = last_bit ? ST_DONE : ST_WORD;
            end
            ST_DONE: begin
                done    = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q  <= '0;
            word_q <= '0;
            ca_q   <= 1'b0;
            cb_q   <= 1'b0;
            q_q    <= 1'b0;
            hold_q <= '0;
        end else if (go) begin
            bit_q  <= '0;
            word_q <= '0;
            ca_q   <= 1'b0;
            cb_q   <= 1'b0;
            q_q    <= 1'b0;
        end else if (state_q == ST_WORD) begin
            ca_q   <= pe_ca;
            cb_q   <= pe_cb;
            q_q    <= pe_q;
            hold_q <= pe_z[WORD_W-1:1];
            if (!last_word) word_q <= word_q + AW'(1);
        end else if (state_q == ST_FOLD) begin
            ca_q   <= 1'b0;
            cb_q   <= 1'b0;
            word_q <= '0;
            bit_q  <= bit_q + IW'(1);
        end
    end

    always_comb begin
        x_addr = AW'(int'(bit_q) / WORD_W);
        xi     = x_word[int'(bit_q) % WORD_W];
    end

    assign z_raddr = busy ? word_q : rd_addr;
    assign rd_data = z_word;

    mm_wordfile #(.W(WORD_W), .N(NW), .AW(AW)) u_xfile (
        .clk(clk), .rst_n(rst_n), .clr(1'b0),
        .we(ld_ok && (ld_sel == SEL_X)), .waddr(ld_addr), .wdata(ld_data),
        .raddr(x_addr), .rdata(x_word)
    );

    mm_wordfile #(.W(WORD_W), .N(NW), .AW(AW)) u_yfile (
        .clk(clk), .rst_n(rst_n), .clr(1'b0),
        .we(ld_ok && (ld_sel == SEL_Y)), .waddr(ld_addr), .wdata(ld_data),
        .raddr(word_q), .rdata(y_word)
    );

    mm_wordfile #(.W(WORD_W), .N(NW), .AW(AW)) u_mfile (
        .clk(clk), .rst_n(rst_n), .clr(1'b0),
        .we(ld_ok && (ld_sel == SEL_M)), .waddr(ld_addr), .wdata(ld_data),
        .raddr(word_q), .rdata(m_word)
    );

    mm_wordfile #(.W(WORD_W), .N(NW), .AW(AW)) u_zfile (
        .clk(clk), .rst_n(rst_n), .clr(go),
        .we(z_we), .waddr(z_waddr), .wdata(z_wdata),
        .raddr(z_raddr), .rdata(z_word)
    );

    mm_word_pe #(.W(WORD_W)) u_pe (
        .first (word_q == '0),
        .xi    (xi),
        .q_in  (q_q),
        .ca_in (ca_q),
        .cb_in (cb_q),
        .z_in  (z_word),
        .y_in  (y_word),
        .m_in  (m_word),
        .q_out (pe_q),
        .ca_out(pe_ca),
        .cb_out(pe_cb),
        .z_out (pe_z)
    );

endmodule

// File: rtl/mont_mul_chk.sv
`timescale 1ns/1ps
module mont_mul_chk #(
    parameter int WORD_W = 16,
    parameter int NWORDS = 16,
    parameter int AW     = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [AW-1:0]     rd_addr,
    input logic [WORD_W-1:0] rd_data
);

    localparam int LAT = (NWORDS * WORD_W + 2) * (NWORDS + 2);

    int busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_cnt <= 0;
        else if (done) busy_cnt <= 0;
        else if (busy) busy_cnt <= busy_cnt + 1;
    end

    // R3
    done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_cnt == LAT));

    // R4
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R4
    start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done) |=> busy);

    // R4
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(rd_addr) -> $stable(rd_data)));

endmodule

bind mont_mul mont_mul_chk #(.WORD_W(WORD_W), .NWORDS(NWORDS), .AW(AW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
);

// File: tb/mont_mul_bench.sv
`timescale 1ns/1ps
module mont_mul_bench;

    localparam int W     = 4;
    localparam int NWD   = 2;
    localparam int NW    = NWD + 1;
    localparam int AW    = $clog2(NW);
    localparam int NBITS = NWD * W + 2;
    localparam int LAT   = NBITS * (NW + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          ld_en = 1'b0;
    logic [1:0]    ld_sel = 2'd0;
    logic [AW-1:0] ld_addr = '0;
    logic [W-1:0]  ld_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [W-1:0]  rd_data;
    logic          busy, done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mont_mul #(.WORD_W(W), .NWORDS(NWD)) u_mont_mul (
        .clk(clk), .rst_n(rst_n), .start(start),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr), .ld_data(ld_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint ref_mm(input longint x, input longint y, input longint m);
        longint t;
        t = (x * y) % m;
        for (int k = 0; k < NBITS; k++) begin
            if (t % 2 == 1) t = t + m;
            t = t / 2;
        end
        return t;
    endfunction

    task automatic load_word(input logic [1:0] sel, input int addr, input logic [W-1:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = sel; ld_addr = AW'(addr); ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // R8: select 0 = X, 1 = Y, 2 = M, word 0 least significant
    task automatic load_op(input logic [1:0] sel, input longint v);
        for (int k = 0; k < NW; k++) load_word(sel, k, W'(v >> (k * W)));
    endtask

    task automatic read_res(output longint r);
        r = 0;
        for (int k = 0; k < NW; k++) begin
            @(negedge clk);
            rd_addr = AW'(k);
            #1;
            r = r | (longint'(rd_data) << (k * W));
        end
    endtask

    task automatic run(input longint x, input longint y, input longint m,
                       input bit disturb, output longint r);
        int lat;
        load_op(2'd0, x);
        load_op(2'd1, y);
        load_op(2'd2, m);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R4 busy after start", longint'(busy), 1);
        lat = 0;
        while (!done && lat < 500) begin
            if (disturb && lat == 5) begin
                // R5 and R4: load and restart attempts mid-run
                ld_en = 1'b1; ld_sel = 2'd2; ld_addr = '0; ld_data = '0;
                start = 1'b1;
            end else begin
                ld_en = 1'b0;
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        ld_en = 1'b0;
        start = 1'b0;
        check(lat == LAT, "R3 latency", lat, LAT);
        check(busy == 1'b0, "R4 busy low at done", longint'(busy), 0);
        @(negedge clk);
        check(done == 1'b0, "R3 done single cycle", longint'(done), 0);
        read_res(r);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        longint r, e, r2, e2;
        longint vals [5];
        repeat (3) @(negedge clk);
        // R6
        check(busy == 1'b0, "R6 busy reset", longint'(busy), 0);
        check(done == 1'b0, "R6 done reset", longint'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (longint m = 3; m <= 255; m += 6) begin
            vals = '{0, 1, m - 1, m, 2 * m - 1};
            for (int a = 0; a < 5; a++) begin
                for (int b = 0; b < 5; b++) begin
                    run(vals[a], vals[b], m, 1'b0, r);
                    e = ref_mm(vals[a], vals[b], m);
                    check(r == e || r == e + m, "R1,R8 product", r, e);
                    check(r < 2 * m, "R2 range", r, 2 * m);
                    if (a == 0) check(r == 0, "R7 cleared start", r, 0);
                end
            end
            // R2: chain the previous result back in as X
            e2 = ref_mm(r, vals[4], m);
            run(r, vals[4], m, 1'b0, r2);
            check(r2 == e2 || r2 == e2 + m, "R2 chained", r2, e2);
        end

        for (longint m = 251; m >= 201; m -= 10) begin
            run(m + 7, 2 * m - 3, m, 1'b1, r);
            e = ref_mm(m + 7, 2 * m - 3, m);
            check(r == e || r == e + m, "R5 load ignored while busy", r, e);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule